// File: doc/BRIEF.md
# UART Register Interface

This block is the bus-facing register file of a 16550-style serial port. A processor reaches it through a single-cycle synchronous port that carries a word-aligned byte offset, a write enable, 16-bit write data and a size code. The block returns read data and an error indication on the following cycle. Every register holds one byte in bits 7:0. Bits 15:8 of read data are always zero, and bits 15:8 of write data are discarded.

Serialization, baud generation, FIFOs and DMA live outside the block. On the transmit side the block issues a one-cycle byte strobe and watches an idle level. On the receive side it sees a byte with a valid flag and returns a consume pulse. A bit in line control remaps the first two offsets onto the divisor bytes. A loopback bit in modem control routes a transmitted byte back into a one-deep slot, which the next receive-buffer read drains. Line status combines sticky bits with the live transfer state and loses its sticky part when it is read.

Top module: `uart_regif`

## Requirements
- R1: After reset, the divisor-low byte reads 0x0001, the identification offset (0x08) reads 0x0001, and line status (0x14) holds sticky bits 0x60. Every other register reads 0x0000, and the strobes tx_valid_o and tx_event_o are low.
- R2: Read data and the error flags appear on the cycle after the request. Only bits 7:0 of write data are stored, and rdata_o[15:8] is always zero.
- R3: With line-control (0x0C) bit 7 set, offset 0x00 reads and writes divisor-low and offset 0x04 reads and writes divisor-high. With that bit clear, offset 0x04 is interrupt enable and the divisor bytes keep their values.
- R4: A size_i other than 1 (16-bit) sets err_o and err_width_o whatever the address, and the access changes no register.
- R5: A correctly sized access to an unaligned offset, to 0x20, or to any offset of 0x28 or above sets err_o with err_width_o low and changes no register.
- R6: Writes to offsets 0x08, 0x14 and 0x18 have no effect. Modem control (0x10), scratch (0x1C) and global control (0x24) are read/write byte storage.
- R7: A line-status read returns the sticky bits OR-ed with the live bits and then clears the sticky bits. The live bits are bit 0 = data ready, bit 5 = hold empty and bit 6 = transmitter empty, and bits 5 and 6 both equal tx_idle_i.
- R8: A write to offset 0x00 with bit 7 of line control clear pulses tx_valid_o for one cycle with the byte on tx_data_o. When interrupt-enable bit 1 is set, tx_event_o pulses in the same cycle.
- R9: With modem-control bit 4 set, a transmitted byte is captured in a one-deep slot and data ready reads 1. The next receive-buffer read returns that byte and empties the slot.
- R10: In loopback with the slot empty, a receive-buffer read returns the previous receive value and never raises rx_ready_o. Data ready then ignores rx_valid_i.
- R11: Outside loopback, data ready equals rx_valid_i. A receive-buffer read while rx_valid_i is high returns rx_data_i and raises rx_ready_o during the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| size_i | input | 2 | Access size code, only 1 (16-bit) is legal |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid on the cycle after a read |
| err_o | output | 1 | Access failed, cycle after the request |
| err_width_o | output | 1 | Failure was a size error |
| tx_valid_o | output | 1 | One-cycle transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| tx_idle_i | input | 1 | Transmit path idle |
| tx_event_o | output | 1 | One-cycle transmit interrupt event |
| rx_valid_i | input | 1 | Receive byte available |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive byte consumed at this clock edge |

## Verification
The consume pulse rx_ready_o is combinational, so the bench samples it in the request cycle, one time step after the inputs settle. Read data, the error flags, tx_valid_o, tx_data_o and tx_event_o all come from a single register stage. They are therefore due in the cycle after the request edge, and the scoreboard monitor samples them a quarter period after that edge. The expected value of each access goes into a queue when the access is driven, and the monitor takes it out at that fixed sampling point.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_RBR_THR, SEL_IER, SEL_DLL, SEL_DLH, SEL_IIR,
    SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR, SEL_GCTL
  } reg_sel_e;

  // word slot index (offset / 4)
  localparam int unsigned SLOT_DATA = 0;
  localparam int unsigned SLOT_IER  = 1;
  localparam int unsigned SLOT_IIR  = 2;
  localparam int unsigned SLOT_LCR  = 3;
  localparam int unsigned SLOT_MCR  = 4;
  localparam int unsigned SLOT_LSR  = 5;
  localparam int unsigned SLOT_MSR  = 6;
  localparam int unsigned SLOT_SCR  = 7;
  localparam int unsigned SLOT_GCTL = 9;

  localparam int unsigned LCR_DLAB_BIT = 7;
  localparam int unsigned IER_TX_BIT   = 1;
  localparam int unsigned MCR_LOOP_BIT = 4;
  localparam int unsigned LSR_DR_BIT   = 0;
  localparam int unsigned LSR_THRE_BIT = 5;
  localparam int unsigned LSR_TEMT_BIT = 6;

  localparam logic [7:0] DLL_RST = 8'h01;
  localparam logic [7:0] IIR_VAL = 8'h01;
  localparam logic [7:0] LSR_RST = 8'h60;
endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
#(
  parameter int unsigned AW        = 6,
  parameter int unsigned SW        = 2,
  parameter int unsigned SIZE_HALF = 1
) (
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_i,
  input  logic          dlab_i,
  output reg_sel_e      sel_o,
  output logic          err_width_o,
  output logic          err_map_o
);
  localparam int unsigned SLOT_W = AW - 2;

  logic [SLOT_W-1:0] slot;
  logic              aligned;

  assign slot    = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign err_width_o = req_i && (size_i != SW'(SIZE_HALF));

  always_comb begin
    sel_o = SEL_NONE;
    if (req_i && !err_width_o && aligned) begin
      case (slot)
        SLOT_W'(SLOT_DATA): sel_o = dlab_i ? SEL_DLL : SEL_RBR_THR;
        SLOT_W'(SLOT_IER):  sel_o = dlab_i ? SEL_DLH : SEL_IER;
        SLOT_W'(SLOT_IIR):  sel_o = SEL_IIR;
        SLOT_W'(SLOT_LCR):  sel_o = SEL_LCR;
        SLOT_W'(SLOT_MCR):  sel_o = SEL_MCR;
        SLOT_W'(SLOT_LSR):  sel_o = SEL_LSR;
        SLOT_W'(SLOT_MSR):  sel_o = SEL_MSR;
        SLOT_W'(SLOT_SCR):  sel_o = SEL_SCR;
        SLOT_W'(SLOT_GCTL): sel_o = SEL_GCTL;
        default:            sel_o = SEL_NONE;
      endcase
    end
  end

  assign err_map_o = req_i && !err_width_o && (sel_o == SEL_NONE);
endmodule

// File: rtl/uart_regif_rxpath.sv
module uart_regif_rxpath #(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_thr_i,
  input  logic          rd_rbr_i,
  input  logic          loop_en_i,
  input  logic [BW-1:0] thr_byte_i,
  input  logic          rx_valid_i,
  input  logic [BW-1:0] rx_data_i,
  output logic [BW-1:0] rbr_nxt_o,
  output logic          rx_pop_o,
  output logic          dr_live_o
);
  logic [BW-1:0] rbr_q, slot_q;
  logic          slot_full_q;

  always_comb begin
    rbr_nxt_o = rbr_q;
    rx_pop_o  = 1'b0;
    if (slot_full_q) begin
      rbr_nxt_o = slot_q;
    end else if (!loop_en_i && rx_valid_i) begin
      rbr_nxt_o = rx_data_i;
      rx_pop_o  = rd_rbr_i;
    end
  end

  assign dr_live_o = slot_full_q || (!loop_en_i && rx_valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_q       <= '0;
      slot_q      <= '0;
      slot_full_q <= 1'b0;
    end else begin
      if (rd_rbr_i) rbr_q <= rbr_nxt_o;
      if (wr_thr_i && loop_en_i) begin
        slot_q      <= thr_byte_i;
        slot_full_q <= 1'b1;
      end else if (rd_rbr_i && slot_full_q) begin
        slot_full_q <= 1'b0;
      end
    end
  end

  AST_SLOT_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rbr_i && slot_full_q) |=> !slot_full_q) else $error("slot not drained"); // R9
  AST_POP_ONLY_EXTERNAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (rx_valid_i && !loop_en_i && rd_rbr_i)) else $error("bad pop"); // R10
endmodule

// File: rtl/uart_regif_lsr.sv
module uart_regif_lsr
  import uart_regif_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_lsr_i,
  input  logic          dr_live_i,
  input  logic          tx_idle_i,
  output logic [BW-1:0] lsr_view_o
);
  logic [BW-1:0] sticky_q, live;

  always_comb begin
    live = '0;
    live[LSR_DR_BIT]   = dr_live_i;
    live[LSR_THRE_BIT] = tx_idle_i;
    live[LSR_TEMT_BIT] = tx_idle_i;
  end

  assign lsr_view_o = sticky_q | live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sticky_q <= BW'(LSR_RST);
    else if (rd_lsr_i) sticky_q <= '0;
  end

  AST_LSR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lsr_i |=> (lsr_view_o == live)) else $error("sticky not cleared"); // R7
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned AW        = 6,
  parameter int unsigned DW        = 16,
  parameter int unsigned BW        = 8,
  parameter int unsigned SW        = 2,
  parameter int unsigned SIZE_HALF = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          err_width_o,
  output logic          tx_valid_o,
  output logic [BW-1:0] tx_data_o,
  input  logic          tx_idle_i,
  output logic          tx_event_o,
  input  logic          rx_valid_i,
  input  logic [BW-1:0] rx_data_i,
  output logic          rx_ready_o
);
  reg_sel_e      sel;
  logic          err_w, err_m, ok, wr, rd, wr_thr, rd_rbr, rd_lsr, dr_live;
  logic [BW-1:0] wbyte, rbr_nxt, lsr_view, rd_byte;
  logic [BW-1:0] dll_q, dlh_q, ier_q, lcr_q, mcr_q, scr_q, gctl_q;
  logic [DW-1:0] rdata_q;
  logic          err_q, errw_q, txv_q, txe_q;
  logic [BW-1:0] txd_q;
  logic          unused_hi;

  assign wbyte     = wdata_i[BW-1:0];
  assign unused_hi = ^wdata_i[DW-1:BW];

  uart_regif_decode #(.AW(AW), .SW(SW), .SIZE_HALF(SIZE_HALF)) i_decode (
    .req_i       (req_i),
    .addr_i      (addr_i),
    .size_i      (size_i),
    .dlab_i      (lcr_q[LCR_DLAB_BIT]),
    .sel_o       (sel),
    .err_width_o (err_w),
    .err_map_o   (err_m)
  );

  assign ok     = (sel != SEL_NONE);
  assign wr     = ok && we_i;
  assign rd     = ok && !we_i;
  assign wr_thr = wr && (sel == SEL_RBR_THR);
  assign rd_rbr = rd && (sel == SEL_RBR_THR);
  assign rd_lsr = rd && (sel == SEL_LSR);

  uart_regif_rxpath #(.BW(BW)) i_rxpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_thr_i   (wr_thr),
    .rd_rbr_i   (rd_rbr),
    .loop_en_i  (mcr_q[MCR_LOOP_BIT]),
    .thr_byte_i (wbyte),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rbr_nxt_o  (rbr_nxt),
    .rx_pop_o   (rx_ready_o),
    .dr_live_o  (dr_live)
  );

  uart_regif_lsr #(.BW(BW)) i_lsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_lsr_i   (rd_lsr),
    .dr_live_i  (dr_live),
    .tx_idle_i  (tx_idle_i),
    .lsr_view_o (lsr_view)
  );

  always_comb begin
    case (sel)
      SEL_RBR_THR: rd_byte = rbr_nxt;
      SEL_IER:     rd_byte = ier_q;
      SEL_DLL:     rd_byte = dll_q;
      SEL_DLH:     rd_byte = dlh_q;
      SEL_IIR:     rd_byte = BW'(IIR_VAL);
      SEL_LCR:     rd_byte = lcr_q;
      SEL_MCR:     rd_byte = mcr_q;
      SEL_LSR:     rd_byte = lsr_view;
      SEL_SCR:     rd_byte = scr_q;
      SEL_GCTL:    rd_byte = gctl_q;
      default:     rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_q  <= BW'(DLL_RST);
      dlh_q  <= '0;
      ier_q  <= '0;
      lcr_q  <= '0;
      mcr_q  <= '0;
      scr_q  <= '0;
      gctl_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DLL:  dll_q  <= wbyte;
        SEL_DLH:  dlh_q  <= wbyte;
        SEL_IER:  ier_q  <= wbyte;
        SEL_LCR:  lcr_q  <= wbyte;
        SEL_MCR:  mcr_q  <= wbyte;
        SEL_SCR:  scr_q  <= wbyte;
        SEL_GCTL: gctl_q <= wbyte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      errw_q  <= 1'b0;
      txv_q   <= 1'b0;
      txe_q   <= 1'b0;
      txd_q   <= '0;
    end else begin
      rdata_q <= rd ? {{(DW-BW){1'b0}}, rd_byte} : '0;
      err_q   <= err_w || err_m;
      errw_q  <= err_w;
      txv_q   <= wr_thr;
      txe_q   <= wr_thr && ier_q[IER_TX_BIT];
      if (wr_thr) txd_q <= wbyte;
    end
  end

  assign rdata_o     = rdata_q;
  assign err_o       = err_q;
  assign err_width_o = errw_q;
  assign tx_valid_o  = txv_q;
  assign tx_data_o   = txd_q;
  assign tx_event_o  = txe_q;

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:BW] == '0) else $error("upper byte set"); // R2
  AST_WIDTH_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != SW'(SIZE_HALF)) |=> (err_o && err_width_o)) else $error("width prio"); // R4
  AST_FAIL_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ok) |=> ($stable(lcr_q) && $stable(mcr_q) && $stable(scr_q) && $stable(gctl_q)
                        && $stable(ier_q) && $stable(dll_q) && $stable(dlh_q))) else $error("failed access wrote"); // R5
  AST_EVENT_WITH_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_event_o |-> tx_valid_o) else $error("event without byte"); // R8
  AST_ALIAS_KEEPS_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lcr_q[LCR_DLAB_BIT]) |=> $stable(dlh_q)) else $error("divisor written without latch bit"); // R3
endmodule

// File: tb/test_uart_regif.sv
module test_uart_regif;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [1:0]  size_i = 2'd1;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        err_o, err_width_o, tx_valid_o, tx_event_o, rx_ready_o;
  logic [7:0]  tx_data_o;
  logic        tx_idle_i = 1'b0, rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] rd;
    logic        err;
    logic        errw;
    bit          cmp_rd;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_regif i_uart_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
    .err_width_o(err_width_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .tx_idle_i(tx_idle_i), .tx_event_o(tx_event_o), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o)
  );

  task automatic chk(input bit good, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // monitor: pops the expectation of each request a quarter period after its edge
  always begin
    @(posedge clk_i);
    if (rst_ni && req_i) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected response", 16'h0, 16'h1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(err_o === e.err, {e.tag, " err"}, {15'h0, err_o}, {15'h0, e.err});
        if (e.err)
          chk(err_width_o === e.errw, {e.tag, " err_width"}, {15'h0, err_width_o}, {15'h0, e.errw});
        if (e.cmp_rd)
          chk(rdata_o === e.rd, {e.tag, " rdata"}, rdata_o, e.rd);
      end
    end
  end

  task automatic acc(input bit we, input logic [5:0] addr, input logic [15:0] wd, input logic [1:0] sz,
                     input logic [15:0] exp_rd, input bit exp_err, input bit exp_errw,
                     input bit exp_pop, input string tag);
    exp_t e;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = addr; wdata_i = wd; size_i = sz;
    e.rd = exp_rd; e.err = exp_err; e.errw = exp_errw; e.cmp_rd = !we && !exp_err; e.tag = tag;
    exp_q.push_back(e);
    #1;
    chk(rx_ready_o === exp_pop, {tag, " rx_ready"}, {15'h0, rx_ready_o}, {15'h0, exp_pop});
    @(posedge clk_i);
    #1;
    req_i = 1'b0; we_i = 1'b0; size_i = 2'd1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input string tag);
    acc(1'b1, a, d, 2'd1, 16'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] expv, input string tag);
    acc(1'b0, a, 16'h0, 2'd1, expv, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic tx_chk(input bit v, input logic [7:0] d, input bit ev, input string tag);
    #2;
    chk(tx_valid_o === v, {tag, " tx_valid"}, {15'h0, tx_valid_o}, {15'h0, v});
    if (v) chk(tx_data_o === d, {tag, " tx_data"}, {8'h0, tx_data_o}, {8'h0, d});
    chk(tx_event_o === ev, {tag, " tx_event"}, {15'h0, tx_event_o}, {15'h0, ev});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rdata_o === 16'h0 && err_o === 1'b0, "R1 reset outputs", rdata_o, 16'h0);
    chk(tx_valid_o === 1'b0 && tx_event_o === 1'b0, "R1 reset strobes", {14'h0, tx_valid_o, tx_event_o}, 16'h0);

    // R1 reset values, R7 sticky clear
    rd(6'h08, 16'h0001, "R1 iir reset");
    rd(6'h04, 16'h0000, "R1 ier reset");
    rd(6'h0C, 16'h0000, "R1 lcr reset");
    rd(6'h1C, 16'h0000, "R1 scr reset");
    rd(6'h14, 16'h0060, "R7 lsr sticky at reset");
    rd(6'h14, 16'h0000, "R7 lsr cleared by read");
    tx_idle_i = 1'b1;
    rd(6'h14, 16'h0060, "R7 lsr live tx idle");
    tx_idle_i = 1'b0;

    // R3 divisor alias, R2 upper byte dropped
    wr(6'h0C, 16'h0080, "R3 set latch bit");
    rd(6'h00, 16'h0001, "R1 divisor low reset");
    rd(6'h04, 16'h0000, "R3 divisor high reset");
    wr(6'h00, 16'hFF37, "R3 divisor low write");
    tx_chk(1'b0, 8'h0, 1'b0, "R3 no tx in divisor mode");
    rd(6'h00, 16'h0037, "R2 divisor low low byte only");
    wr(6'h04, 16'h0012, "R3 divisor high write");
    rd(6'h04, 16'h0012, "R3 divisor high read");
    wr(6'h0C, 16'h0000, "R3 clear latch bit");
    rd(6'h04, 16'h0000, "R3 ier independent of divisor");
    wr(6'h0C, 16'h0080, "R3 set latch again");
    rd(6'h04, 16'h0012, "R3 divisor high retained");
    wr(6'h0C, 16'h0000, "R3 clear latch again");

    // R4 width errors take priority
    acc(1'b0, 6'h1C, 16'h0, 2'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R4 byte read");
    acc(1'b1, 6'h30, 16'h0, 2'd2, 16'h0, 1'b1, 1'b1, 1'b0, "R4 word write unmapped prio");
    acc(1'b1, 6'h1C, 16'h0055, 2'd0, 16'h0, 1'b1, 1'b1, 1'b0, "R4 byte write scr");
    rd(6'h1C, 16'h0000, "R4 scr unchanged");

    // R5 unmapped
    acc(1'b1, 6'h20, 16'h00AA, 2'd1, 16'h0, 1'b1, 1'b0, 1'b0, "R5 unused slot");
    acc(1'b0, 6'h02, 16'h0, 2'd1, 16'h0, 1'b1, 1'b0, 1'b0, "R5 unaligned");
    acc(1'b0, 6'h3C, 16'h0, 2'd1, 16'h0, 1'b1, 1'b0, 1'b0, "R5 beyond map");
    acc(1'b1, 6'h0E, 16'h0080, 2'd1, 16'h0, 1'b1, 1'b0, 1'b0, "R5 unaligned lcr write");
    rd(6'h0C, 16'h0000, "R5 lcr unchanged");

    // R6 ignored and plain registers
    wr(6'h08, 16'h00AA, "R6 iir write");
    rd(6'h08, 16'h0001, "R6 iir unchanged");
    wr(6'h14, 16'h00FF, "R6 lsr write");
    rd(6'h14, 16'h0000, "R6 lsr unchanged");
    wr(6'h18, 16'h0033, "R6 msr write");
    rd(6'h18, 16'h0000, "R6 msr unchanged");
    wr(6'h1C, 16'h005A, "R6 scr write");
    rd(6'h1C, 16'h005A, "R6 scr read");
    wr(6'h24, 16'h0081, "R6 gctl write");
    rd(6'h24, 16'h0081, "R6 gctl read");
    wr(6'h10, 16'h0003, "R6 mcr write");
    rd(6'h10, 16'h0003, "R6 mcr read");

    // R8 transmit strobe and event
    wr(6'h00, 16'h0041, "R8 thr no event");
    tx_chk(1'b1, 8'h41, 1'b0, "R8 thr no event");
    rd(6'h0C, 16'h0000, "R8 filler");
    tx_chk(1'b0, 8'h0, 1'b0, "R8 strobe one cycle");
    wr(6'h04, 16'h0002, "R8 ier tx enable");
    wr(6'h00, 16'hAB42, "R8 thr with event");
    tx_chk(1'b1, 8'h42, 1'b1, "R8 thr with event");

    // R11 external receive
    rx_valid_i = 1'b1; rx_data_i = 8'h99;
    rd(6'h14, 16'h0001, "R11 data ready external");
    acc(1'b0, 6'h00, 16'h0, 2'd1, 16'h0099, 1'b0, 1'b0, 1'b1, "R11 rbr read pops");
    rx_valid_i = 1'b0;
    rd(6'h14, 16'h0000, "R11 data ready low");

    // R9 / R10 loopback
    wr(6'h10, 16'h0010, "R9 loop enable");
    rx_valid_i = 1'b1; rx_data_i = 8'h77;
    rd(6'h14, 16'h0000, "R10 external ignored in loop");
    wr(6'h00, 16'h005C, "R9 loop thr");
    rd(6'h14, 16'h0001, "R9 data ready slot");
    acc(1'b0, 6'h00, 16'h0, 2'd1, 16'h005C, 1'b0, 1'b0, 1'b0, "R9 rbr returns slot");
    acc(1'b0, 6'h00, 16'h0, 2'd1, 16'h005C, 1'b0, 1'b0, 1'b0, "R10 rbr holds previous");
    rd(6'h14, 16'h0000, "R9 slot empty");
    rx_valid_i = 1'b0;

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2 all responses seen", 16'(exp_q.size()), 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule